// File: doc/BRIEF.md
# Serial-addressed multichannel DAC code register

This block is the digital front end of a multichannel digital-to-analog converter. A host writes it over a three-wire serial link with a bit clock, a data line and a load strobe. Each frame carries fourteen bits. The low four bits name a channel and the upper ten bits carry a code. When the load strobe rises, the code goes into the register of the named channel. Each channel register drives one 10-bit code output. The resistor ladder and the analog buffers are outside this block.

The serial pins are sampled through a synchronizer on a faster system clock, and the block acts on the rising edges it detects there. A strap input picks the bit order of the data field. A serial output carries the bit that falls off the end of the fourteen-stage shift register, so a second device can take it as its data input and share the bit clock and load strobe. A clear input forces every channel to code zero. The channel count is a parameter, so one design covers both the ten-channel build and the eight-channel build.

Top module: `dacfe_top`

## Requirements
- R1: After power-on reset every channel code is zero and the serial output is 0.
- R2: On each detected rising edge of the serial clock, the data line is shifted into the 14-bit register. The first bit sent is frame bit D0 and the fourteenth is D13.
- R3: A channel is updated only on a rising edge of the load strobe, with exactly one update per rising edge. Bit clocks that arrive while the strobe stays high change no channel.
- R4: The address field is D3..D0, with D3 as its most significant bit. A value n from 1 to NCH writes channel n, exposed at chan_codes[(n-1)*10 +: 10]. Value 0 and every value above NCH leave all channels unchanged.
- R5: With the order strap high, the channel code is D13..D4, with D13 as the MSB.
- R6: With the order strap low, the channel code has D4 as the MSB and D13 as the LSB. The address field is read the same way in both strap settings.
- R7: The serial output presents register bit D0, which is the bit shifted in fourteen clocks earlier, and changes only after a detected serial-clock edge. Two chained devices sent 28 bits followed by one load take the first frame in the far device and the second frame in the near device.
- R8: While clear is high, every channel reads zero. When clear and a load edge arrive together, clear wins.
- R9: In an eight-channel build (NCH=8), addresses 9 and 10 change no channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ser_clk | input | 1 | Serial bit clock |
| ser_dat | input | 1 | Serial data |
| ser_load | input | 1 | Load strobe; a rising edge commits the frame |
| msb_first | input | 1 | Order strap: 1 means D13 is the code MSB, 0 means D4 is |
| clear_all | input | 1 | Master clear of all channel codes, active high |
| ser_out | output | 1 | Cascade output, the end bit of the shift register |
| chan_codes | output | NCH*10 | All channel codes, with channel n at bits (n-1)*10 +: 10 |

## Verification
A load edge and the master clear can reach the channel bank in the same system-clock cycle. The bench provokes this by raising the load strobe and the clear line on the same clock, so both pass through equal synchronizer depth. It then expects every channel to be zero, both while the lines are held and after they are released. It also expects a later frame to load normally. The bench also overlaps a held-high load strobe with a full frame of bit clocks and expects no channel to move.

// File: rtl/dacfe_pkg.sv
`timescale 1ns/1ps
package dacfe_pkg;
  // interpretation of the data field, set by the order strap
  typedef enum logic {
    ORD_LSB_LEADS = 1'b0,   // D4 is the code MSB
    ORD_MSB_LEADS = 1'b1    // D13 is the code MSB
  } order_e;

  // Default geometry of one frame
  localparam int unsigned ADDR_BITS = 4;
  localparam int unsigned CODE_BITS = 10;
endpackage

// File: rtl/dacfe_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a bundle of asynchronous inputs.
module dacfe_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/dacfe_edge.sv
`timescale 1ns/1ps
// Rising-edge detector on already-synchronized levels.
module dacfe_edge #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
endmodule

// File: rtl/dacfe_shift.sv
`timescale 1ns/1ps
// Frame shift register: new bits enter at the top, the oldest bit sits at
// index 0 and is presented for cascading.
module dacfe_shift #(
  parameter int unsigned FW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          din,
  output logic [FW-1:0] word,
  output logic          tail
);
  logic [FW-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sr <= '0;
    else if (step) sr <= {din, sr[FW-1:1]};
  end

  assign word = sr;
  assign tail = sr[0];
endmodule

// File: rtl/dacfe_bank.sv
`timescale 1ns/1ps
// Channel code registers with sparse address decode and master clear.
module dacfe_bank #(
  parameter int unsigned NCH = 10,
  parameter int unsigned CW  = 10,
  parameter int unsigned AW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [CW-1:0]     code,
  output logic [NCH-1:0]    sel,
  output logic [NCH*CW-1:0] codes
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CW-1:0] reg_q;

    assign sel[g] = wr && !clr && (addr == AW'(g + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_q <= '0;
      else if (clr)    reg_q <= '0;
      else if (sel[g]) reg_q <= code;
    end

    assign codes[g*CW +: CW] = reg_q;
  end
endmodule

// File: rtl/dacfe_top.sv
`timescale 1ns/1ps
module dacfe_top
  import dacfe_pkg::*;
#(
  parameter int unsigned NCH         = 10,
  parameter int unsigned CW          = CODE_BITS,
  parameter int unsigned AW          = ADDR_BITS,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_load,
  input  logic              msb_first,
  input  logic              clear_all,
  output logic              ser_out,
  output logic [NCH*CW-1:0] chan_codes
);
  localparam int unsigned FW = AW + CW;

  // bit order swap of the data field
  function automatic logic [CW-1:0] flip_code(input logic [CW-1:0] v);
    logic [CW-1:0] r;
    for (int b = 0; b < CW; b++) r[b] = v[CW-1-b];
    return r;
  endfunction

  // synchronized pin levels: {clear, strap, load, data, clock}
  logic [4:0] pins_s;
  logic [1:0] rises;

  dacfe_sync #(.W(5), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({clear_all, msb_first, ser_load, ser_dat, ser_clk}),
    .q     (pins_s)
  );

  dacfe_edge #(.W(2)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   ({pins_s[2], pins_s[0]}),
    .rise  (rises)
  );

  // named internal events for the checker
  logic          sclk_rise, load_rise, clr_s, dat_s;
  order_e        order_s;
  logic [FW-1:0] frame;
  logic [AW-1:0] frame_addr;
  logic [CW-1:0] frame_raw, frame_code;
  logic [NCH-1:0] upd_sel;

  assign sclk_rise = rises[0];
  assign load_rise = rises[1];
  assign dat_s     = pins_s[1];
  assign order_s   = order_e'(pins_s[3]);
  assign clr_s     = pins_s[4];

  dacfe_shift #(.FW(FW)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (sclk_rise),
    .din   (dat_s),
    .word  (frame),
    .tail  (ser_out)
  );

  assign frame_addr = frame[AW-1:0];
  assign frame_raw  = frame[FW-1:AW];
  assign frame_code = (order_s == ORD_MSB_LEADS) ? frame_raw : flip_code(frame_raw);

  dacfe_bank #(.NCH(NCH), .CW(CW), .AW(AW)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_s),
    .wr    (load_rise),
    .addr  (frame_addr),
    .code  (frame_code),
    .sel   (upd_sel),
    .codes (chan_codes)
  );
endmodule

// File: rtl/dacfe_chk.sv
`timescale 1ns/1ps
module dacfe_chk #(
  parameter int unsigned NCH = 10,
  parameter int unsigned CW  = 10,
  parameter int unsigned AW  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk_rise,
  input logic              load_rise,
  input logic              clr_s,
  input logic [AW-1:0]     frame_addr,
  input logic [NCH-1:0]    upd_sel,
  input logic              ser_out,
  input logic [NCH*CW-1:0] chan_codes
);
  localparam logic [AW-1:0] LAST = AW'(NCH);

  // R1: reset holds the channels at zero
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |=> chan_codes == '0);

  // R3: no channel moves without a load edge or a clear
  p_hold_without_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_rise && !clr_s) |=> $stable(chan_codes));

  // R4: at most one channel written per edge
  p_single_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_sel));

  // R4 / R9: out-of-range addresses leave every channel alone
  p_bad_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_rise && !clr_s && (frame_addr == '0 || frame_addr > LAST))
      |=> $stable(chan_codes));

  // R7: the cascade output only moves after a serial-clock edge
  p_tail_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(ser_out));

  // R8: clear wins over everything
  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |=> chan_codes == '0);
endmodule

bind dacfe_top dacfe_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sclk_rise  (sclk_rise),
  .load_rise  (load_rise),
  .clr_s      (clr_s),
  .frame_addr (frame_addr),
  .upd_sel    (upd_sel),
  .ser_out    (ser_out),
  .chan_codes (chan_codes)
);

// File: tb/sim_dacfe_top.sv
`timescale 1ns/1ps
module sim_dacfe_top;
  localparam int NCH0 = 10, NCH1 = 8, CW = 10, AW = 4, FW = 14, HOLD = 6;
  localparam int VW = NCH0 * CW;

  logic clk = 0, rst_n = 0, sck = 0, sdi = 0, ld = 0, msbf = 1, clr = 0;
  logic so0, so1;
  logic [NCH0*CW-1:0] codes0;
  logic [NCH1*CW-1:0] codes1;

  always #2.5 clk = ~clk;

  dacfe_top #(.NCH(NCH0)) u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(sck), .ser_dat(sdi), .ser_load(ld),
    .msb_first(msbf), .clear_all(clr), .ser_out(so0), .chan_codes(codes0));

  // far device in the chain, reduced channel count
  dacfe_top #(.NCH(NCH1)) u1 (
    .clk(clk), .rst_n(rst_n), .ser_clk(sck), .ser_dat(so0), .ser_load(ld),
    .msb_first(msbf), .clear_all(clr), .ser_out(so1), .chan_codes(codes1));

  // reference model
  logic [CW-1:0] m0 [NCH0];
  logic [CW-1:0] m1 [NCH1];
  logic [FW-1:0] sr0 = '0, sr1 = '0;

  typedef struct { int dev; logic [VW-1:0] v; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;

  function automatic logic [CW-1:0] want_code(logic [FW-1:0] f, logic norm);
    logic [CW-1:0] r;
    for (int b = 0; b < CW; b++) r[b] = norm ? f[AW+b] : f[FW-1-b];
    return r;
  endfunction

  task automatic chk1(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // monitor: pops expected channel images and compares at a quiet edge
  initial begin
    forever begin
      item_t it;
      logic [VW-1:0] act;
      wait (q.size() != 0);
      @(negedge clk);
      it = q.pop_front();
      act = (it.dev == 0) ? codes0 : {{(VW-NCH1*CW){1'b0}}, codes1};
      checks++;
      if (act !== it.v) begin
        errors++;
        $display("FAIL %s dev%0d: got %h expected %h", it.tag, it.dev, act, it.v);
      end
    end
  end

  // driver side: push both devices' model images and wait for the monitor
  task automatic expect_now(string tag);
    item_t a, b;
    a.dev = 0; a.tag = tag; a.v = '0;
    b.dev = 1; b.tag = tag; b.v = '0;
    for (int c = 0; c < NCH0; c++) a.v[c*CW +: CW] = m0[c];
    for (int c = 0; c < NCH1; c++) b.v[c*CW +: CW] = m1[c];
    q.push_back(a);
    q.push_back(b);
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  // one serial bit; R2 shift model and R7 cascade output check
  task automatic sclk_bit(logic b);
    @(negedge clk) sdi = b;
    repeat (HOLD) @(negedge clk);
    sck = 1;
    sr1 = {sr0[0], sr1[FW-1:1]};
    sr0 = {b, sr0[FW-1:1]};
    repeat (HOLD) @(negedge clk);
    chk1("R7 near tail", so0, sr0[0]);
    chk1("R7 far tail", so1, sr1[0]);
    sck = 0;
  endtask

  task automatic shift_frame(logic [FW-1:0] f);
    for (int i = 0; i < FW; i++) sclk_bit(f[i]);
  endtask

  task automatic model_load();
    int a0, a1;
    a0 = int'(sr0[AW-1:0]);
    a1 = int'(sr1[AW-1:0]);
    if (a0 >= 1 && a0 <= NCH0) m0[a0-1] = want_code(sr0, msbf);
    if (a1 >= 1 && a1 <= NCH1) m1[a1-1] = want_code(sr1, msbf);
  endtask

  task automatic model_clear();
    for (int c = 0; c < NCH0; c++) m0[c] = '0;
    for (int c = 0; c < NCH1; c++) m1[c] = '0;
  endtask

  task automatic load_pulse();
    @(negedge clk) ld = 1;
    model_load();
    repeat (HOLD) @(negedge clk);
    ld = 0;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic send(logic [AW-1:0] addr, logic [CW-1:0] data, string tag);
    shift_frame({data, addr});
    load_pulse();
    expect_now(tag);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk1("R1 near tail", so0, 1'b0);
    chk1("R1 far tail", so1, 1'b0);
    expect_now("R1 reset codes");

    // R2 R4 R5 normal order writes
    send(4'd1, 10'h2A5, "R5 ch1");
    send(4'd10, 10'h3FF, "R4 ch10");
    send(4'd5, 10'h001, "R5 ch5");
    send(4'd8, 10'h200, "R2 ch8");

    // R4 ignored addresses
    send(4'd0, 10'h155, "R4 addr0");
    send(4'd11, 10'h0F0, "R4 addr11");
    send(4'd15, 10'h3C3, "R4 addr15");

    // R6 reversed order
    msbf = 0;
    send(4'd2, 10'h001, "R6 ch2");
    send(4'd7, 10'h155, "R6 ch7");
    send(4'd1, 10'h3FE, "R6 ch1");
    msbf = 1;

    // R7 cascade: far frame first, then near frame, one load
    shift_frame({10'h1B4, 4'd3});
    shift_frame({10'h0C7, 4'd4});
    load_pulse();
    expect_now("R7 cascade");

    // R9 reduced build ignores 9 and 10
    shift_frame({10'h111, 4'd9});
    shift_frame({10'h222, 4'd9});
    load_pulse();
    expect_now("R9 addr9");
    shift_frame({10'h333, 4'd10});
    shift_frame({10'h044, 4'd6});
    load_pulse();
    expect_now("R9 addr10");

    // R3 one update per load edge, bit clocks under a held strobe
    shift_frame({10'h0AA, 4'd3});
    @(negedge clk) ld = 1;
    model_load();
    repeat (HOLD) @(negedge clk);
    expect_now("R3 first edge");
    shift_frame({10'h355, 4'd3});
    expect_now("R3 held strobe");
    ld = 0;
    repeat (HOLD) @(negedge clk);
    expect_now("R3 after fall");

    // R8 clear alone
    @(negedge clk) clr = 1;
    model_clear();
    repeat (HOLD) @(negedge clk);
    expect_now("R8 clear");
    clr = 0;
    repeat (HOLD) @(negedge clk);

    // R8 clear and load edge together
    send(4'd4, 10'h3A1, "R8 refill");
    shift_frame({10'h2B2, 4'd6});
    @(negedge clk) begin clr = 1; ld = 1; end
    model_clear();
    repeat (HOLD) @(negedge clk);
    expect_now("R8 clear with load");
    clr = 0; ld = 0;
    repeat (HOLD) @(negedge clk);
    expect_now("R8 after release");
    send(4'd6, 10'h2B2, "R8 load after clear");

    // R2 random frames in both strap settings
    for (int n = 0; n < 40; n++) begin
      msbf = 1'($urandom_range(0, 1));
      send(4'($urandom_range(0, 15)), 10'($urandom_range(0, 1023)), "R2 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule